// File: doc/BRIEF.md
# Viterbi Decoder Error Collector and Interrupt Controller

This block sits beside a Viterbi decoding engine and turns its fault conditions into a single level interrupt for a host processor. Each time the engine presents a frame configuration, the block validates it against two host-programmed limits. The limit that applies depends on the traceback mode. The block also raises a flag for a traceback mode code that is not permitted. Three further fault strobes come straight from the engine: receive-side symbol count, transmit-side symbol count, and metric max/min.

Every fault sets its own sticky flag. A summary bit is the OR of all of them. While any flag is set, the block holds the engine paused. A read of the error register returns the flags and clears them all as a side effect. The interrupt is masked by an enable bit that has separate set and clear addresses. An end-of-interrupt write drops the interrupt line for one cycle while a fault is still pending, so an edge-sensitive host controller sees a fresh edge.

The host reaches the block through a plain register bus with an address, a write strobe, a read strobe, write data and combinational read data. All addresses are word indices.

Top module: `dec_err_irq`

## Requirements
- R1: After reset every error flag is clear, the interrupt enable is 0, `irq_o` and `pause_o` are low, and both limit registers read as all ones (frame limit 0xFFFF at address 5, window limit 0x1FF at address 6).
- R2: When `cfg_valid` is high with mode 0 (tailed), a frame length strictly greater than the frame limit sets error bit 5. A length equal to the limit sets nothing.
- R3: When `cfg_valid` is high with mode 1 (mixed) or mode 2 (convergent), R+C strictly greater than the window limit sets error bit 6. Equality sets nothing, and the frame length is not checked in these modes.
- R4: When `cfg_valid` is high with mode 3 (not allowed), error bit 4 is set and neither length check is applied.
- R5: A one-cycle pulse on `ev_sym_rx`, `ev_sym_tx` or `ev_maxmin` sets error bit 1, 2 or 3 respectively, visible from the next cycle.
- R6: Error register (address 0) bit 0 is the OR of bits 6:1. `pause_o` is high whenever any flag is set.
- R7: Flags stay set until the host reads address 0. The read returns the current flags, and the flags are clear from the next cycle, except a fault arriving in the same cycle as the read, which stays set.
- R8: Writing 1 in bit 0 at address 2 sets the enable, and writing 1 in bit 0 at address 3 clears it. Writing 0 at either address changes nothing. Reading address 2 or 3 returns the enable in bit 0.
- R9: `irq_o` is the AND of the enable and the summary bit. Address 1 bit 0 reads the same masked state.
- R10: A write of 0 in bit 0 to address 4 while `irq_o` is high drops `irq_o` for exactly one cycle, after which it returns. A write of 1 there has no effect.
- R11: Address 5 (frame limit, low 16 bits) and address 6 (window limit, low 9 bits) are writable and read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read of address 0 clears flags) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| cfg_valid | input | 1 | Frame configuration present for checking |
| cfg_mode | input | 2 | Traceback mode: 0 tailed, 1 mixed, 2 convergent, 3 not allowed |
| cfg_frame_len | input | 16 | Frame length F |
| cfg_win_r | input | 8 | Reliability length R |
| cfg_win_c | input | 8 | Convergence length C |
| ev_sym_rx | input | 1 | Receive symbol-count fault strobe |
| ev_sym_tx | input | 1 | Transmit symbol-count fault strobe |
| ev_maxmin | input | 1 | Metric max/min fault strobe |
| irq_o | output | 1 | Level interrupt to host |
| pause_o | output | 1 | Holds the engine paused while any flag is set |

## Verification
Two events can land on the same clock edge: the clear-on-read of the error register and the arrival of a new engine fault. The bench raises a receive fault, then pulses a transmit fault in exactly the cycle that reads address 0. The returned value must show only the older receive flag. A second read must then show only the transmit flag, which proves the new fault won over the clear and the old one was dropped.

// File: rtl/dec_err_irq_pkg.sv
package dec_err_irq_pkg;

    typedef enum logic [1:0] {
        TB_TAILED = 2'd0,
        TB_MIXED  = 2'd1,
        TB_CONV   = 2'd2,
        TB_BAD    = 2'd3
    } tb_mode_e;

    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned N_CAUSES = 6;

    // cause vector index; error register bit = index + 1
    localparam int unsigned C_SYM_RX  = 0;
    localparam int unsigned C_SYM_TX  = 1;
    localparam int unsigned C_MAXMIN  = 2;
    localparam int unsigned C_MODE    = 3;
    localparam int unsigned C_FLEN    = 4;
    localparam int unsigned C_WINDOW  = 5;

    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd0;
    localparam logic [ADDR_W-1:0] A_IRQST = 3'd1;
    localparam logic [ADDR_W-1:0] A_ENSET = 3'd2;
    localparam logic [ADDR_W-1:0] A_ENCLR = 3'd3;
    localparam logic [ADDR_W-1:0] A_EOI   = 3'd4;
    localparam logic [ADDR_W-1:0] A_FMAX  = 3'd5;
    localparam logic [ADDR_W-1:0] A_RCMAX = 3'd6;

endpackage

// File: rtl/dec_err_cfg_check.sv
module dec_err_cfg_check
    import dec_err_irq_pkg::*;
#(
    parameter int unsigned LEN_W = 16,
    parameter int unsigned WIN_W = 8
) (
    input  logic             valid,
    input  logic [1:0]       mode,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [WIN_W-1:0] win_r,
    input  logic [WIN_W-1:0] win_c,
    input  logic [LEN_W-1:0] frame_lim,
    input  logic [WIN_W:0]   window_lim,
    output logic             bad_mode,
    output logic             long_frame,
    output logic             wide_window
);
    localparam int unsigned SUM_W = WIN_W + 1;

    logic [SUM_W-1:0] win_sum;
    tb_mode_e         m;

    always_comb begin
        m           = tb_mode_e'(mode);
        win_sum     = SUM_W'(win_r) + SUM_W'(win_c);
        bad_mode    = valid && (m == TB_BAD);
        long_frame  = valid && (m == TB_TAILED) && (frame_len > frame_lim);
        wide_window = valid && ((m == TB_MIXED) || (m == TB_CONV)) && (win_sum > window_lim);
    end

endmodule

// File: rtl/dec_err_reg_read.sv
module dec_err_reg_read
    import dec_err_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned WIN_W  = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [N_CAUSES-1:0] causes,
    input  logic                enable,
    input  logic                masked,
    input  logic [LEN_W-1:0]    frame_lim,
    input  logic [WIN_W:0]      window_lim,
    output logic [DATA_W-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_FLAGS: rdata[N_CAUSES:0] = {causes, |causes};
            A_IRQST: rdata[0]          = masked;
            A_ENSET,
            A_ENCLR: rdata[0]          = enable;
            A_FMAX:  rdata[LEN_W-1:0]  = frame_lim;
            A_RCMAX: rdata[WIN_W:0]    = window_lim;
            default: rdata             = '0;
        endcase
    end

endmodule

// File: rtl/dec_err_irq.sv
module dec_err_irq
    import dec_err_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned WIN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cfg_valid,
    input  logic [1:0]        cfg_mode,
    input  logic [LEN_W-1:0]  cfg_frame_len,
    input  logic [WIN_W-1:0]  cfg_win_r,
    input  logic [WIN_W-1:0]  cfg_win_c,
    input  logic              ev_sym_rx,
    input  logic              ev_sym_tx,
    input  logic              ev_maxmin,
    output logic              irq_o,
    output logic              pause_o
);
    localparam int unsigned RC_W = WIN_W + 1;

    typedef struct packed {
        logic [N_CAUSES-1:0] causes;
        logic                enable;
        logic                gap;
        logic [LEN_W-1:0]    frame_lim;
        logic [RC_W-1:0]     window_lim;
    } state_t;

    state_t st_d, st_q;

    logic                bad_mode, long_frame, wide_window;
    logic [N_CAUSES-1:0] set_vec;
    logic                pending;
    logic                masked;
    logic                flags_rd;
    logic                en_q;
    logic [N_CAUSES-1:0] cause_q;

    dec_err_cfg_check #(.LEN_W(LEN_W), .WIN_W(WIN_W)) u_check (
        .valid       (cfg_valid),
        .mode        (cfg_mode),
        .frame_len   (cfg_frame_len),
        .win_r       (cfg_win_r),
        .win_c       (cfg_win_c),
        .frame_lim   (st_q.frame_lim),
        .window_lim  (st_q.window_lim),
        .bad_mode    (bad_mode),
        .long_frame  (long_frame),
        .wide_window (wide_window)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[C_SYM_RX] = ev_sym_rx;
        set_vec[C_SYM_TX] = ev_sym_tx;
        set_vec[C_MAXMIN] = ev_maxmin;
        set_vec[C_MODE]   = bad_mode;
        set_vec[C_FLEN]   = long_frame;
        set_vec[C_WINDOW] = wide_window;
    end

    assign pending  = |st_q.causes;
    assign masked   = st_q.enable & pending;
    assign flags_rd = bus_rd && (bus_addr == A_FLAGS);

    always_comb begin
        st_d        = st_q;
        st_d.gap    = 1'b0;
        st_d.causes = (flags_rd ? '0 : st_q.causes) | set_vec;
        if (bus_wr) begin
            unique case (bus_addr)
                A_ENSET: if (bus_wdata[0]) st_d.enable = 1'b1;
                A_ENCLR: if (bus_wdata[0]) st_d.enable = 1'b0;
                A_EOI:   st_d.gap = !bus_wdata[0] && masked;
                A_FMAX:  st_d.frame_lim  = bus_wdata[LEN_W-1:0];
                A_RCMAX: st_d.window_lim = bus_wdata[RC_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.causes     <= '0;
            st_q.enable     <= 1'b0;
            st_q.gap        <= 1'b0;
            st_q.frame_lim  <= '1;
            st_q.window_lim <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    dec_err_reg_read #(.DATA_W(DATA_W), .LEN_W(LEN_W), .WIN_W(WIN_W)) u_read (
        .addr       (bus_addr),
        .causes     (st_q.causes),
        .enable     (st_q.enable),
        .masked     (masked),
        .frame_lim  (st_q.frame_lim),
        .window_lim (st_q.window_lim),
        .rdata      (bus_rdata)
    );

    assign irq_o   = masked & ~st_q.gap;
    assign pause_o = pending;
    assign en_q    = st_q.enable;
    assign cause_q = st_q.causes;

endmodule

// File: rtl/dec_err_irq_chk.sv
module dec_err_irq_chk
    import dec_err_irq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic                wbit0,
    input logic                cfg_valid,
    input logic [1:0]          cfg_mode,
    input logic                ev_sym_rx,
    input logic                ev_sym_tx,
    input logic                ev_maxmin,
    input logic                irq_o,
    input logic                pause_o,
    input logic                en,
    input logic [N_CAUSES-1:0] cause
);
    logic rd_flags;
    assign rd_flags = bus_rd && (bus_addr == A_FLAGS);

    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en && pause_o));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_flags |=> ((cause & $past(cause)) == $past(cause)));

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && !ev_sym_rx && !ev_sym_tx && !ev_maxmin && !cfg_valid) |=> !pause_o);

    p_rx_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sym_rx |=> cause[C_SYM_RX]);

    p_bad_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_mode == 2'd3) |=> cause[C_MODE]);

    p_enable_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ENSET && wbit0) |=> en);

    p_enable_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ENCLR && wbit0) |=> !en);

    p_eoi_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EOI && !wbit0 && irq_o) |=> !irq_o);

endmodule

bind dec_err_irq dec_err_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .wbit0     (bus_wdata[0]),
    .cfg_valid (cfg_valid),
    .cfg_mode  (cfg_mode),
    .ev_sym_rx (ev_sym_rx),
    .ev_sym_tx (ev_sym_tx),
    .ev_maxmin (ev_maxmin),
    .irq_o     (irq_o),
    .pause_o   (pause_o),
    .en        (en_q),
    .cause     (cause_q)
);

// File: tb/sim_dec_err_irq.sv
module sim_dec_err_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cfg_valid = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [15:0] cfg_frame_len = '0;
    logic [7:0]  cfg_win_r = '0;
    logic [7:0]  cfg_win_c = '0;
    logic        ev_sym_rx = 1'b0;
    logic        ev_sym_tx = 1'b0;
    logic        ev_maxmin = 1'b0;
    logic        irq_o;
    logic        pause_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dec_err_irq u0 (.*);

    // {mode, frame_len, R, C, expected error register[6:0]}; limits 100 / 50
    localparam logic [40:0] VEC [8] = '{
        {2'd0, 16'd100, 8'd0,  8'd0,  7'h00},
        {2'd0, 16'd101, 8'd0,  8'd0,  7'h21},
        {2'd0, 16'd101, 8'd30, 8'd30, 7'h21},
        {2'd1, 16'd500, 8'd25, 8'd25, 7'h00},
        {2'd1, 16'd0,   8'd25, 8'd26, 7'h41},
        {2'd2, 16'd500, 8'd40, 8'd20, 7'h41},
        {2'd2, 16'd500, 8'd0,  8'd0,  7'h00},
        {2'd3, 16'd500, 8'd60, 8'd60, 7'h11}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        chk("R1 pause", {31'd0, pause_o}, 32'd0);
        bus_read(3'd0, v); chk("R1 flags", v, 32'h0);
        bus_read(3'd2, v); chk("R1 enable", v, 32'h0);
        bus_read(3'd5, v); chk("R1 frame limit", v, 32'hFFFF);
        bus_read(3'd6, v); chk("R1 window limit", v, 32'h1FF);

        // R11 limit registers
        bus_write(3'd5, 32'd100);
        bus_write(3'd6, 32'd50);
        bus_read(3'd5, v); chk("R11 frame limit", v, 32'd100);
        bus_read(3'd6, v); chk("R11 window limit", v, 32'd50);

        // R2 R3 R4 R6 vector walk
        foreach (VEC[i]) begin
            cfg_mode      = VEC[i][40:39];
            cfg_frame_len = VEC[i][38:23];
            cfg_win_r     = VEC[i][22:15];
            cfg_win_c     = VEC[i][14:7];
            cfg_valid     = 1'b1;
            @(negedge clk);
            cfg_valid = 1'b0;
            chk("R6 pause per vector", {31'd0, pause_o}, {31'd0, VEC[i][6:0] != 7'd0});
            bus_read(3'd0, v);
            chk("R2/R3/R4 vector flags", v, {25'd0, VEC[i][6:0]});
        end

        // R5 strobes
        ev_maxmin = 1'b1; @(negedge clk); ev_maxmin = 1'b0;
        bus_read(3'd0, v); chk("R5 maxmin", v, 32'h09);
        ev_sym_tx = 1'b1; @(negedge clk); ev_sym_tx = 1'b0;
        bus_read(3'd0, v); chk("R5 tx", v, 32'h05);

        // R7 sticky, then clear-on-read racing a new fault
        ev_sym_rx = 1'b1; @(negedge clk); ev_sym_rx = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 pause held", {31'd0, pause_o}, 32'd1);
        ev_sym_tx = 1'b1;
        bus_read(3'd0, v);
        ev_sym_tx = 1'b0;
        chk("R7 sticky read", v, 32'h03);
        bus_read(3'd0, v); chk("R7 same-cycle fault kept", v, 32'h05);
        bus_read(3'd0, v); chk("R7 cleared", v, 32'h00);
        chk("R7 pause released", {31'd0, pause_o}, 32'd0);

        // R8 R9 enable and masking
        ev_sym_tx = 1'b1; @(negedge clk); ev_sym_tx = 1'b0;
        chk("R9 masked while disabled", {31'd0, irq_o}, 32'd0);
        bus_write(3'd2, 32'd0);
        bus_read(3'd2, v); chk("R8 set with 0 ignored", v, 32'd0);
        chk("R8 irq after set 0", {31'd0, irq_o}, 32'd0);
        bus_write(3'd2, 32'd1);
        chk("R9 irq enabled", {31'd0, irq_o}, 32'd1);
        bus_read(3'd3, v); chk("R8 enable via clr addr", v, 32'd1);
        bus_read(3'd1, v); chk("R9 status", v, 32'd1);

        // R10 end of interrupt
        bus_write(3'd4, 32'd1);
        chk("R10 eoi 1 ignored", {31'd0, irq_o}, 32'd1);
        bus_write(3'd4, 32'd0);
        chk("R10 gap", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        chk("R10 reassert", {31'd0, irq_o}, 32'd1);

        // R8 clear
        bus_write(3'd3, 32'd0);
        chk("R8 clr with 0 ignored", {31'd0, irq_o}, 32'd1);
        bus_write(3'd3, 32'd1);
        chk("R8 disabled", {31'd0, irq_o}, 32'd0);
        bus_read(3'd1, v); chk("R9 status masked", v, 32'd0);
        chk("R6 pause still set", {31'd0, pause_o}, 32'd1);

        done = 1'b1;
        summary();
    end
endmodule